// File: doc/BRIEF.md
# Bypass-Protected Programmable Clock Divider Channel

This channel produces one output clock. In normal operation the output is a fast source clock divided by an 8-bit integer field, where a field of zero means division by 256. The output can instead carry a slow reference clock, either because a static bypass input is held high or because the channel is in the middle of a divide change. A glitch-free selector switches between the two clocks. It uses a two-flop enable handshake in each clock domain, so neither clock is cut part-way through a phase.

Software asks for a new divisor by pulsing a write request together with a requested divisor. The request is wider than the field. Requests of 256 or more saturate to the divide-by-256 encoding, and a request of zero also encodes to it. The change sequencer is a state machine in the reference domain. Its states are:

- `S_IDLE`: waiting for a request.
- `S_ENTER`: bypass is requested; the state waits until the selector reports the reference is driving the output.
- `S_LOAD`: the new field is written.
- `S_HOLD`: the bypass is held for `HOLD_CYC` reference cycles.
- `S_LEAVE`: bypass is released; the state waits until the divided clock drives the output, or ends at once if the static bypass is set.
- `S_DONE`: a one-cycle completion pulse.

The transitions are:

- idle→enter on an accepted write.
- enter→load when the reference is selected.
- load→hold always.
- hold→leave when the hold count ends.
- leave→done when the selector reports the divided clock, or when the static bypass is set.
- done→enter on a new write.
- done→idle otherwise.

After reset the channel sits in bypass with a field of 0 until the first change completes.

Top module: `byp_clkdiv_chan`

## Requirements
- R1: The stored divide field equals the requested divisor for requests 1..255. Requests of 0 and of 256 or more store field 0.
- R2: Once a change completes without static bypass, the output period is N source-clock cycles, where N is the field value and a field of 0 means N = 256. With N = 1 the output is the source clock itself.
- R3: While `byp_force` is 1, the output is the reference clock whatever the field holds, and the field is unchanged.
- R4: After reset, `busy` is 0, `div_field` is 0, and the output is the reference clock.
- R5: `busy` is 1 from the reference edge that accepts a write. The field is written only after the selector reports the reference clock on the output (`S_LOAD` follows `S_ENTER`).
- R6: Bypass is held for at least `HOLD_CYC` reference cycles after the field is written, so `busy` lasts at least `HOLD_CYC`+3 reference cycles.
- R7: A write request made while `busy` is 1 is ignored. The field keeps the value of the change in progress.
- R8: `chg_done` is high for exactly one reference cycle when a change finishes, with `busy` low in that cycle.
- R9: No output high or low phase is shorter than half a source-clock period, including across every bypass switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock to be divided |
| ref_clk | input | 1 | Slow reference clock; also clocks the sequencer |
| rst_n | input | 1 | Asynchronous active-low reset |
| byp_force | input | 1 | Static bypass select: output follows ref_clk while 1 |
| wr_req | input | 1 | One-cycle write request (ref_clk domain) |
| wr_divisor | input | REQ_W | Requested divisor, saturated to the field encoding |
| clk_out | output | 1 | Channel output clock |
| div_field | output | DIV_W | Current divide field (0 means 256) |
| busy | output | 1 | A divide change is in progress |
| chg_done | output | 1 | One-cycle pulse when a change completes |

## Verification
The bench builds the channel with `DIV_W` = 8, `REQ_W` = 16 and `HOLD_CYC` = 3, using a 4 ns source clock against the 20 ns reference. The short hold keeps each change to a handful of reference cycles, so many changes fit in one run, including the longest divide of 256. The narrow 8-bit field with a 16-bit request exposes both saturation paths (exactly 256, and above 256). The fast source makes divide-by-1 the shortest legal phase, which is the yardstick the runt-pulse monitor measures against.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ENTER = 3'd1,
        S_LOAD  = 3'd2,
        S_HOLD  = 3'd3,
        S_LEAVE = 3'd4,
        S_DONE  = 3'd5
    } seq_state_t;

endpackage

// File: rtl/div_field_enc.sv
module div_field_enc #(
    parameter int DIV_W = 8,
    parameter int REQ_W = 16
) (
    input  logic [REQ_W-1:0] req,
    output logic [DIV_W-1:0] field
);
    localparam int MAX_DIV = 1 << DIV_W;

    logic saturate;

    always_comb begin
        saturate = (req >= REQ_W'(MAX_DIV)) || (req == '0);
        field    = saturate ? '0 : req[DIV_W-1:0];
    end

    // R1: a nonzero field only ever comes from an in-range request
    always_comb begin
        if (!$isunknown(req)) begin
            p_field_range_r1: assert ((field == '0) || ((req < REQ_W'(MAX_DIV)) && (req != '0)));
        end
    end
endmodule

// File: rtl/div_counter.sv
module div_counter #(
    parameter int DIV_W = 8
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] field,
    output logic             div_clk
);
    localparam int NW = DIV_W + 1;

    logic [NW-1:0]    len;
    logic [NW-1:0]    hi_len;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_nxt;
    logic             q;

    always_comb begin
        len     = (field == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, field};
        hi_len  = len >> 1;
        cnt_nxt = ({1'b0, cnt} >= (len - NW'(1))) ? '0 : cnt + DIV_W'(1);
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            q   <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            q   <= ({1'b0, cnt_nxt} < hi_len);
        end
    end

    assign div_clk = (len == NW'(1)) ? src_clk : q;
endmodule

// File: rtl/clk_glitchfree_sel.sv
module clk_glitchfree_sel (
    input  logic ref_clk,
    input  logic div_clk,
    input  logic rst_n,
    input  logic sel_ref,
    output logic ref_on,
    output logic div_on_s,
    output logic clk_out
);
    logic r1, r2;
    logic d1, d2;
    logic ds1, ds2;

    // reference branch: enabled only once the divided branch is off
    always_ff @(negedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            r1 <= 1'b1;
            r2 <= 1'b1;
        end else begin
            r1 <= sel_ref & ~d2;
            r2 <= r1;
        end
    end

    // divided branch: enabled only once the reference branch is off
    always_ff @(negedge div_clk or negedge rst_n) begin
        if (!rst_n) begin
            d1 <= 1'b0;
            d2 <= 1'b0;
        end else begin
            d1 <= ~sel_ref & ~r2;
            d2 <= d1;
        end
    end

    // divided-branch enable brought into the reference domain for the sequencer
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            ds1 <= 1'b0;
            ds2 <= 1'b0;
        end else begin
            ds1 <= d2;
            ds2 <= ds1;
        end
    end

    assign ref_on   = r2;
    assign div_on_s = ds2;
    assign clk_out  = (ref_clk & r2) | (div_clk & d2);

    // R9: the two branch enables are never on together
    p_excl_enable_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !(r2 && d2));
endmodule

// File: rtl/chg_seq_fsm.sv
module chg_seq_fsm
    import clkdiv_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int HOLD_CYC = 10
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [DIV_W-1:0] wr_field,
    input  logic             byp_force,
    input  logic             ref_on,
    input  logic             div_on_s,
    output logic             sel_ref,
    output logic             busy,
    output logic             chg_done,
    output logic [DIV_W-1:0] div_field
);
    localparam int HCW = $clog2(HOLD_CYC + 1);

    seq_state_t       state, state_nxt;
    logic [HCW-1:0]   hold_cnt;
    logic [DIV_W-1:0] pend;
    logic             init_byp;
    logic             accept;
    logic             hold_end;

    assign accept   = wr_req && ((state == S_IDLE) || (state == S_DONE));
    assign hold_end = (hold_cnt == HCW'(HOLD_CYC - 1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (accept) state_nxt = S_ENTER;
            S_ENTER: if (ref_on && !div_on_s) state_nxt = S_LOAD;
            S_LOAD:  state_nxt = S_HOLD;
            S_HOLD:  if (hold_end) state_nxt = S_LEAVE;
            S_LEAVE: if (div_on_s || byp_force) state_nxt = S_DONE;
            S_DONE:  state_nxt = accept ? S_ENTER : S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= '0;
            div_field <= '0;
            hold_cnt  <= '0;
            init_byp  <= 1'b1;
        end else begin
            if (accept) pend <= wr_field;
            if (state == S_LOAD) begin
                div_field <= pend;
                init_byp  <= 1'b0;
                hold_cnt  <= '0;
            end else if (state == S_HOLD) begin
                hold_cnt <= hold_cnt + HCW'(1);
            end
        end
    end

    always_comb begin
        busy     = (state == S_ENTER) || (state == S_LOAD) ||
                   (state == S_HOLD)  || (state == S_LEAVE);
        chg_done = (state == S_DONE);
        sel_ref  = byp_force || init_byp || (state == S_ENTER) ||
                   (state == S_LOAD) || (state == S_HOLD);
    end

    // R5: the field is loaded only while the reference drives the output
    p_ref_at_load_r5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state == S_LOAD) |-> (ref_on && !div_on_s));

    // R7: a write during a change leaves the pending value alone
    p_ignore_busy_r7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (busy && wr_req) |=> $stable(pend));

    // R6: the hold ends only after the full count
    p_hold_len_r6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        ((state == S_LEAVE) && ($past(state) == S_HOLD)) |-> ($past(hold_cnt) == HCW'(HOLD_CYC - 1)));

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        chg_done |=> !chg_done);
endmodule

// File: rtl/byp_clkdiv_chan.sv
module byp_clkdiv_chan #(
    parameter int DIV_W    = 8,
    parameter int REQ_W    = 16,
    parameter int HOLD_CYC = 10
) (
    input  logic             src_clk,
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             byp_force,
    input  logic             wr_req,
    input  logic [REQ_W-1:0] wr_divisor,
    output logic             clk_out,
    output logic [DIV_W-1:0] div_field,
    output logic             busy,
    output logic             chg_done
);
    logic [DIV_W-1:0] enc_field;
    logic             div_clk;
    logic             sel_ref;
    logic             ref_on;
    logic             div_on_s;

    div_field_enc #(.DIV_W(DIV_W), .REQ_W(REQ_W)) u_enc (
        .req   (wr_divisor),
        .field (enc_field)
    );

    chg_seq_fsm #(.DIV_W(DIV_W), .HOLD_CYC(HOLD_CYC)) u_seq (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .wr_field  (enc_field),
        .byp_force (byp_force),
        .ref_on    (ref_on),
        .div_on_s  (div_on_s),
        .sel_ref   (sel_ref),
        .busy      (busy),
        .chg_done  (chg_done),
        .div_field (div_field)
    );

    div_counter #(.DIV_W(DIV_W)) u_div (
        .src_clk (src_clk),
        .rst_n   (rst_n),
        .field   (div_field),
        .div_clk (div_clk)
    );

    clk_glitchfree_sel u_sel (
        .ref_clk  (ref_clk),
        .div_clk  (div_clk),
        .rst_n    (rst_n),
        .sel_ref  (sel_ref),
        .ref_on   (ref_on),
        .div_on_s (div_on_s),
        .clk_out  (clk_out)
    );
endmodule

// File: tb/byp_clkdiv_chan_test.sv
`timescale 1ns/1ps
module byp_clkdiv_chan_test;
    localparam int DIV_W = 8;
    localparam int REQ_W = 16;
    localparam int HOLD  = 3;
    localparam int SRC_P = 4;
    localparam int REF_P = 20;

    logic src_clk = 0, ref_clk = 0, rst_n = 0;
    logic byp_force = 0, wr_req = 0;
    logic [REQ_W-1:0] wr_divisor = '0;
    logic clk_out, busy, chg_done;
    logic [DIV_W-1:0] div_field;

    int tests = 0, fails = 0, glitches = 0;
    int exp_field_q[$];
    int exp_per_q[$];
    bit mon_act = 0;
    bit glitch_on = 0;
    realtime last_edge = 0;

    always #(SRC_P/2.0) src_clk = ~src_clk;
    always #(REF_P/2) ref_clk = ~ref_clk;

    byp_clkdiv_chan #(.DIV_W(DIV_W), .REQ_W(REQ_W), .HOLD_CYC(HOLD)) uut (
        .src_clk(src_clk), .ref_clk(ref_clk), .rst_n(rst_n), .byp_force(byp_force),
        .wr_req(wr_req), .wr_divisor(wr_divisor), .clk_out(clk_out),
        .div_field(div_field), .busy(busy), .chg_done(chg_done)
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic measure(output int per);
        realtime t0;
        @(posedge clk_out);
        @(posedge clk_out);
        t0 = $realtime;
        @(posedge clk_out);
        per = int'($realtime - t0);
    endtask

    // runt monitor
    initial forever begin
        @(clk_out);
        if (glitch_on && (($realtime - last_edge) < SRC_P/2.0 - 0.5)) glitches++;
        last_edge = $realtime;
    end

    // scoreboard monitor: pops expectations on each completion
    initial forever begin
        int ef, ep, per;
        @(negedge ref_clk);
        if (rst_n && chg_done && exp_field_q.size() > 0) begin
            mon_act = 1;
            ef = exp_field_q.pop_front();
            ep = exp_per_q.pop_front();
            chk(div_field == DIV_W'(ef), "R1", "stored field", int'(div_field), ef);
            measure(per);
            chk(per == ep, "R2", "divided period ns", per, ep);
            mon_act = 0;
        end
    end

    function automatic int enc(input int rq);
        return (rq == 0 || rq >= 256) ? 0 : rq;
    endfunction

    // driver: second request (if use_b) is issued while busy and must be ignored
    task automatic change(input int a, input bit use_b, input int b);
        int ef, cyc;
        ef = enc(a);
        exp_field_q.push_back(ef);
        exp_per_q.push_back(((ef == 0) ? 256 : ef) * SRC_P);
        @(posedge ref_clk); #1;
        wr_req = 1; wr_divisor = REQ_W'(a);
        @(posedge ref_clk); #1;
        chk(busy == 1'b1, "R5", "busy after accepted write", int'(busy), 1);
        if (use_b) begin
            wr_divisor = REQ_W'(b);
        end else begin
            wr_req = 0;
        end
        @(posedge ref_clk); #1;
        wr_req = 0;
        cyc = 2;
        forever begin
            @(negedge ref_clk);
            if (chg_done) break;
            if (busy) cyc++;
        end
        chk(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
        chk(cyc >= HOLD + 3, "R6", "busy length cycles", cyc, HOLD + 3);
        @(negedge ref_clk);
        chk(chg_done == 1'b0, "R8", "done one cycle", int'(chg_done), 0);
        wait (exp_field_q.size() == 0 && !mon_act);
        if (use_b) chk(div_field == DIV_W'(ef), "R7", "write while busy ignored", int'(div_field), ef);
    endtask

    initial begin
        repeat (150000) @(posedge ref_clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int per;
        repeat (3) @(posedge ref_clk);
        #3 rst_n = 1;
        @(negedge ref_clk);
        chk(busy == 1'b0, "R4", "busy after reset", int'(busy), 0);
        chk(div_field == '0, "R4", "field after reset", int'(div_field), 0);
        chk(chg_done == 1'b0, "R4", "done after reset", int'(chg_done), 0);
        measure(per);
        chk(per == REF_P, "R4", "reset output period", per, REF_P);
        glitch_on = 1;

        change(4, 0, 0);
        change(1, 0, 0);
        change(7, 0, 0);
        change(300, 0, 0);   // R1 saturation above range
        change(2, 0, 0);
        change(256, 0, 0);   // R1 exactly 256
        change(5, 1, 9);     // R7 second write while busy
        change(3, 0, 0);

        // R3 static bypass
        @(negedge ref_clk); byp_force = 1;
        repeat (6) @(negedge ref_clk);
        measure(per);
        chk(per == REF_P, "R3", "bypass output period", per, REF_P);
        chk(div_field == 8'd3, "R3", "field unchanged in bypass", int'(div_field), 3);
        @(negedge ref_clk); byp_force = 0;
        repeat (6) @(negedge ref_clk);
        measure(per);
        chk(per == 3 * SRC_P, "R3", "period after bypass cleared", per, 3 * SRC_P);

        change(0, 0, 0);     // R1 zero request
        chk(glitches == 0, "R9", "runt phases seen", glitches, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule